// File: doc/BRIEF.md
# Character-Cell Text Display Generator

This block drives a 640x480 monochrome display from one 25.175 MHz pixel clock and shows a 64-column by 48-row text screen. Each screen cell is 10x10 pixels. An 8x8 glyph fills the top-left corner of the cell, and the last two pixel columns and the last two scanlines stay dark. The block reads a 4K-byte video memory through a read-only port. Offsets 0x000 to 0xBFF hold one character code per cell, row-major. Offsets 0xC00 to 0xFFF hold a rewritable font of 128 glyphs, with 8 bytes per glyph and one byte per scanline.

The memory read is synchronous with one clock of latency. During the last three pixels of every cell the block fetches ahead for the next cell. It first presents the next cell's code address, then the glyph-byte address, and then loads an 8-bit shift register exactly at the cell's first pixel. The shift register shifts pixels out MSB first. The memory port is fixed-rate: the raster never waits, so the port has no valid/ready handshake and no back-pressure. Memory contents may change at any time through another port. A change takes effect at the next fetch of the affected cell.

The single pixel bit drives red, green and blue together. Sync pulses are active low. A synchronous active-high reset returns the raster to the top-left pixel.

Top module: `vga_text_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, the output pixel is 0 and both syncs are high. Reset places the raster at pixel 0 of line 0. Because no prefetch precedes it, the first cell of line 0 in the first frame after reset is dark.
- R2: Each line is 800 pixels. Horizontal sync is low for raster pixels 656 to 751 and high elsewhere.
- R3: Each frame is (rows x 10 + 45) lines, which is 525 at the default size. Vertical sync is low for lines rows x 10 + 10 and rows x 10 + 11 (490 and 491 at the default) and high elsewhere.
- R4: At pixel 7 of each cell, the memory address is row*64 + column of the next cell. At the last cell of a line, the next cell is column 0 of the following line. The address is given only when that next cell is visible.
- R5: At pixel 8 of a cell, the address is 0xC00 + code[6:0]*8 + glyph line, where the code is the byte just read. Bit 7 of the code has no effect on the image.
- R6: Inside a visible cell, pixel x (0 to 7) of glyph line y (0 to 7) equals bit 7-x of the glyph byte. Outputs appear one clock after the raster position they belong to.
- R7: Cell pixel columns 8 and 9, and cell scanlines 8 and 9, are dark.
- R8: Outside the 640 x (rows x 10) active region the pixel is 0.
- R9: Codes and glyph bytes rewritten during vertical blanking appear in the next frame.
- R10: The red, green and blue outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vram_addr | output | 12 | Video memory read address |
| vram_rdata | input | 8 | Read data, valid one clock after the address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Pixel on |
| green | output | 1 | Pixel on |
| blue | output | 1 | Pixel on |

## Verification
The pixel, the syncs and the colour outputs are registered, so each one is due one clock after its raster position. The bench advances its own raster model at every rising edge. At the following falling edge it compares the outputs against the position held before that edge. The address is combinational from the current raster position and the previous read, so it is checked against the position reached after the edge: the code address at cell pixel 7, and the glyph address at cell pixel 8, using the code the bench memory returned. Memory rewrites are made only in vertical blanking, and the expected image of the next frame is computed from the new contents.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CODE  = 2'd1,
    PH_GLYPH = 2'd2,
    PH_LOAD  = 2'd3
  } fetch_phase_e;
endpackage

// File: rtl/vtg_timing.sv
`timescale 1ns/1ps
module vtg_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int CELL_W = 10,
  parameter int CELL_H = 10,
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int SW = 4,
  parameter int CW = 7,
  parameter int LW = 4,
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [SW-1:0] sub,
  output logic [CW-1:0] col,
  output logic [LW-1:0] lin,
  output logic [RW-1:0] row,
  output logic          active,
  output logic          hsync_n,
  output logic          vsync_n
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = H_VIS + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_VIS + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic line_end, frame_end;
  assign line_end  = (hcnt == HW'(H_TOTAL - 1));
  assign frame_end = (vcnt == VW'(V_TOTAL - 1));
  assign active    = (hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0; vcnt <= '0; sub <= '0; col <= '0; lin <= '0; row <= '0;
      hsync_n <= 1'b1; vsync_n <= 1'b1;
    end else begin
      hsync_n <= !((hcnt >= HW'(HS_BEG)) && (hcnt < HW'(HS_END)));
      vsync_n <= !((vcnt >= VW'(VS_BEG)) && (vcnt < VW'(VS_END)));
      if (line_end) begin
        hcnt <= '0; sub <= '0; col <= '0;
        if (frame_end) begin
          vcnt <= '0; lin <= '0; row <= '0;
        end else begin
          vcnt <= vcnt + 1'b1;
          if (lin == LW'(CELL_H - 1)) begin
            lin <= '0; row <= row + 1'b1;
          end else begin
            lin <= lin + 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
        if (sub == SW'(CELL_W - 1)) begin
          sub <= '0; col <= col + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R1: reset returns the raster to the top-left pixel
  a_r1_reset_origin: assert property (@(posedge clk)
    rst |=> (hcnt == '0) && (vcnt == '0));
  // R2: line length
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hcnt == '0) && (sub == '0));
  // R3: one line step per wrap, until the frame ends
  a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_end) |=> (vcnt == $past(vcnt) + 1'b1));
endmodule

// File: rtl/vtg_fetch.sv
`timescale 1ns/1ps
module vtg_fetch import vtg_pkg::*; #(
  parameter int COLS      = 64,
  parameter int ROWS      = 48,
  parameter int CELL_W    = 10,
  parameter int CELL_H    = 10,
  parameter int FONT_ROWS = 8,
  parameter int CODES     = 128,
  parameter int V_TOTAL   = 525,
  parameter int HCELLS    = 80,
  parameter int AW        = 12,
  parameter int FONT_BASE = 'hC00,
  parameter int VW = 10,
  parameter int SW = 4,
  parameter int CW = 7,
  parameter int LW = 4,
  parameter int RW = 6
) (
  input  logic [SW-1:0] sub,
  input  logic [CW-1:0] col,
  input  logic [LW-1:0] lin,
  input  logic [RW-1:0] row,
  input  logic [VW-1:0] vcnt,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] addr,
  output logic          load,
  output logic [7:0]    load_data
);
  localparam int GLB       = $clog2(FONT_ROWS);
  localparam int CODE_BITS = $clog2(CODES);

  fetch_phase_e    phase;
  logic            last_col, fvalid;
  logic [RW-1:0]   nrow, frow;
  logic [LW-1:0]   nlin, flin;
  logic [CW-1:0]   fcol;

  always_comb begin
    if (sub == SW'(CELL_W - 3))      phase = PH_CODE;
    else if (sub == SW'(CELL_W - 2)) phase = PH_GLYPH;
    else if (sub == SW'(CELL_W - 1)) phase = PH_LOAD;
    else                             phase = PH_IDLE;
  end

  // position of the line that follows the current one
  always_comb begin
    if (vcnt == VW'(V_TOTAL - 1)) begin
      nrow = '0; nlin = '0;
    end else if (lin == LW'(CELL_H - 1)) begin
      nrow = row + 1'b1; nlin = '0;
    end else begin
      nrow = row; nlin = lin + 1'b1;
    end
  end

  assign last_col = (col == CW'(HCELLS - 1));
  assign frow     = last_col ? nrow : row;
  assign flin     = last_col ? nlin : lin;
  assign fcol     = last_col ? '0 : col + 1'b1;
  assign fvalid   = (fcol < CW'(COLS)) && (frow < RW'(ROWS)) && (flin < LW'(FONT_ROWS));

  always_comb begin
    addr = '0;
    unique case (phase)
      PH_CODE:  if (fvalid) addr = AW'(frow) * AW'(COLS) + AW'(fcol);
      PH_GLYPH: if (fvalid) addr = AW'(FONT_BASE) + (AW'(rdata[CODE_BITS-1:0]) << GLB) + AW'(flin);
      default:  addr = '0;
    endcase
  end

  assign load      = (phase == PH_LOAD);
  assign load_data = fvalid ? rdata : 8'h00;
endmodule

// File: rtl/vtg_shift.sv
`timescale 1ns/1ps
module vtg_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         active,
  output logic         pix
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      pix   <= 1'b0;
    end else begin
      pix   <= shreg[W-1] && active;
      shreg <= load ? load_data : {shreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/vga_text_gen.sv
`timescale 1ns/1ps
module vga_text_gen #(
  parameter int COLS      = 64,
  parameter int ROWS      = 48,
  parameter int CELL_W    = 10,
  parameter int CELL_H    = 10,
  parameter int FONT_ROWS = 8,
  parameter int CODES     = 128,
  parameter int AW        = 12,
  parameter int FONT_BASE = 'hC00,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BP      = 48,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] vram_addr,
  input  logic [7:0]    vram_rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          red,
  output logic          green,
  output logic          blue
);
  localparam int H_VIS   = COLS * CELL_W;
  localparam int V_VIS   = ROWS * CELL_H;
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCELLS  = H_TOTAL / CELL_W;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int SW = $clog2(CELL_W);
  localparam int CW = $clog2(HCELLS);
  localparam int LW = $clog2(CELL_H);
  localparam int RW = $clog2(V_TOTAL / CELL_H + 1);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [SW-1:0] sub;
  logic [CW-1:0] col;
  logic [LW-1:0] lin;
  logic [RW-1:0] row;
  logic          active, load, pix;
  logic [7:0]    load_data;

  vtg_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CELL_W(CELL_W), .CELL_H(CELL_H),
    .HW(HW), .VW(VW), .SW(SW), .CW(CW), .LW(LW), .RW(RW)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .sub(sub), .col(col),
    .lin(lin), .row(row), .active(active), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  vtg_fetch #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .FONT_ROWS(FONT_ROWS), .CODES(CODES), .V_TOTAL(V_TOTAL), .HCELLS(HCELLS),
    .AW(AW), .FONT_BASE(FONT_BASE),
    .VW(VW), .SW(SW), .CW(CW), .LW(LW), .RW(RW)
  ) u_fetch (
    .sub(sub), .col(col), .lin(lin), .row(row), .vcnt(vcnt),
    .rdata(vram_rdata), .addr(vram_addr), .load(load), .load_data(load_data)
  );

  vtg_shift #(.W(8)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .active(active), .pix(pix)
  );

  assign red   = pix;
  assign green = pix;
  assign blue  = pix;

  // R1: outputs idle during and right after reset
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> !pix && hsync_n && vsync_n);
  // R8: nothing lit outside the active region
  a_r8_blank_dark: assert property (@(posedge clk) disable iff (rst)
    !((hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS))) |=> !pix);
  // R7: inter-character gap columns and lines stay dark
  a_r7_gap_dark: assert property (@(posedge clk) disable iff (rst)
    ((sub >= SW'(FONT_ROWS)) || (lin >= LW'(FONT_ROWS))) |=> !pix);
  // R6: the shifter loads right before a cell's first pixel
  a_r6_load_align: assert property (@(posedge clk) disable iff (rst)
    load |=> (sub == '0));
  // R2: sync low only after raster pixels inside the sync window
  a_r2_hsync_window: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> ($past(hcnt) >= HW'(H_VIS + H_FP)) && ($past(hcnt) < HW'(H_VIS + H_FP + H_SYNC)));
endmodule

// File: tb/test_vga_text_gen.sv
`timescale 1ns/1ps
module test_vga_text_gen;
  localparam int ROWS_T   = 8;
  localparam int H_TOT    = 800;
  localparam int V_VIS_T  = ROWS_T * 10;
  localparam int V_TOT    = V_VIS_T + 45;
  localparam int N_CYC    = H_TOT * V_TOT + H_TOT * 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] vram_addr;
  logic [7:0]  vram_rdata = 8'h00;
  logic        hsync_n, vsync_n, red, green, blue;
  logic [7:0]  mem [4096];
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  always @(posedge clk) vram_rdata <= mem[vram_addr];

  vga_text_gen #(.ROWS(ROWS_T)) i_vga_text_gen (
    .clk(clk), .rst(rst), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_pix(int h, int v, int fr);
    int col, sub, row, lin;
    logic [7:0] code, g;
    if (h >= 640 || v >= V_VIS_T) return 1'b0;
    col = h / 10; sub = h % 10; row = v / 10; lin = v % 10;
    if (sub >= 8 || lin >= 8) return 1'b0;
    if (fr == 0 && v == 0 && h < 10) return 1'b0;
    code = mem[row * 64 + col];
    g = mem[12'hC00 + int'(code & 8'h7F) * 8 + lin];
    return g[7 - sub];
  endfunction

  function automatic string pix_tag(int h, int v, int fr);
    if (h >= 640 || v >= V_VIS_T) return "R8";
    if (fr == 0 && v == 0 && h < 10) return "R1";
    if ((h % 10) >= 8 || (v % 10) >= 8) return "R7";
    if (fr > 0 && v < 10) return "R9";
    if (mem[(v / 10) * 64 + h / 10][7]) return "R5";
    return "R6";
  endfunction

  int hm, vm, frame, ph, pv, pf;

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom());
    mem[0] = 8'h85; mem[1] = 8'h05;
    for (int k = 0; k < 8; k++)
      mem[12'hC00 + 5 * 8 + k] = (k == 0) ? 8'hFF : (k == 7) ? 8'hAA : 8'h81;
    for (int k = 0; k < 8; k++) mem[12'hC00 + 127 * 8 + k] = 8'hFF;
    mem[(ROWS_T - 1) * 64 + 63] = 8'h7F;

    repeat (3) begin
      @(negedge clk);
      chk("R1", "pix in reset", 32'(red), 32'd0);
      chk("R1", "hsync in reset", 32'(hsync_n), 32'd1);
      chk("R1", "vsync in reset", 32'(vsync_n), 32'd1);
    end
    rst = 1'b0;
    hm = 0; vm = 0; frame = 0;

    for (int n = 0; n < N_CYC; n++) begin
      @(posedge clk);
      ph = hm; pv = vm; pf = frame;
      if (hm == H_TOT - 1) begin
        hm = 0;
        if (vm == V_TOT - 1) begin vm = 0; frame++; end
        else vm++;
      end else hm++;
      @(negedge clk);
      chk(pix_tag(ph, pv, pf), "pixel", 32'(red), 32'(exp_pix(ph, pv, pf)));
      chk("R10", "colours", {30'd0, green, blue}, {30'd0, red, red});
      chk("R2", "hsync", 32'(hsync_n), 32'(!(ph >= 656 && ph < 752)));
      chk("R3", "vsync", 32'(vsync_n), 32'(!(pv >= V_VIS_T + 10 && pv < V_VIS_T + 12)));
      begin
        int col, fcol, frow, flin, nv, sub;
        col = hm / 10; sub = hm % 10;
        if (col == 79) begin
          nv = (vm == V_TOT - 1) ? 0 : vm + 1;
          fcol = 0; frow = nv / 10; flin = nv % 10;
        end else begin
          fcol = col + 1; frow = vm / 10; flin = vm % 10;
        end
        if (fcol < 64 && frow < ROWS_T && flin < 8) begin
          if (sub == 7)
            chk("R4", "code address", 32'(vram_addr), 32'(frow * 64 + fcol));
          if (sub == 8)
            chk("R5", "glyph address", 32'(vram_addr),
                32'(12'hC00 + int'(mem[frow * 64 + fcol] & 8'h7F) * 8 + flin));
        end
      end
      if (frame == 0 && vm == V_VIS_T + 20 && hm == 0) begin
        for (int c = 0; c < 64; c++)
          mem[c] = 8'(c % 8) | ((c % 3 == 0) ? 8'h80 : 8'h00);
        for (int k = 0; k < 64; k++) mem[12'hC00 + k] = 8'($urandom());
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 190000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule